// File: doc/BRIEF.md
# Vector ALU Forwarding Pipeline Timing Model

This block is a cycle-accurate timing model of an in-order vector ALU path. Each issued operation names one destination register and up to two source registers. It waits in a small dependency-wait queue until its sources are resolved. It then passes through a four-stage ALU shift pipeline and a single writeback register, where it raises an execution-complete pulse. The block models no data values, only when each operation enters the ALU and when it completes.

A result leaving the last ALU stage is forwarded to the admission logic in that same cycle. An operation that is already waiting for it therefore enters stage 0 one cycle earlier than it would through the completion event. Each cycle is evaluated in a fixed order: the writeback event, then the last stage moving into writeback with its forwarding value, then the shift, then admission of at most one waiting operation. A per-register count of in-flight writers tracks which sources are still outstanding.

In the text below, cycle numbers count from the cycle in which the issue handshake (`issue_valid` and `issue_ready` both high) occurs, which is cycle 0.

Top module: `valu_fwd_pipe`

## Requirements
- R1: While `rst` is high at a clock edge, all ALU stages, the writeback register, the wait queue and the writer counts are cleared. In the cycle after reset there is no enter pulse and no completion pulse, `issue_ready` is high, and an operation accepted before the reset never completes.
- R2: An operation with no used sources shows its enter pulse in cycle 2 and its completion pulse (`exec_valid` with `exec_dst` equal to its destination) in cycle 6.
- R3: Every completion pulse for a destination follows the enter pulse of the same operation by exactly 4 cycles.
- R4: Take a dependent operation that is waiting in the queue while its producer occupies the last ALU stage. It enters stage 0 in the cycle right after that one, with `enter_fwd` high, and completes 4 cycles after its producer completes. When dependents are chained back to back, the spacing between completions is 4 cycles.
- R5: A dependent that reaches the queue too late to catch the forwarding value is admitted through the producer's completion event or an idle writer count. `enter_fwd` is low, and the gap between completions equals the issue gap.
- R6: A source whose used flag is low places no constraint on admission, even if its index matches an in-flight destination.
- R7: At most one operation is admitted per cycle. It is the oldest queued operation whose sources are resolved, so a blocked older entry lets a younger independent one pass it.
- R8: An operation that reads the destination of an older operation still in the queue waits until that older operation has been admitted and its result is forwarded or completed.
- R9: When several in-flight operations write the same register, a reader waits for the youngest of them. It can be admitted by forwarding once every older writer to that register is in writeback or already retired.
- R10: The queue holds `Q_DEPTH` operations (default 4). `issue_ready` is low exactly while the queue is full. No accepted operation is lost, and every one completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An operation is offered this cycle |
| issue_ready | output | 1 | Queue has room; the offer is taken when both are high |
| issue_dst | input | RW | Destination register index |
| issue_src_a | input | RW | First source register index |
| issue_src_a_used | input | 1 | First source is a register (low = constant) |
| issue_src_b | input | RW | Second source register index |
| issue_src_b_used | input | 1 | Second source is a register (low = constant) |
| enter_valid | output | 1 | An operation is in ALU stage 0 this cycle |
| enter_dst | output | RW | Destination of that operation |
| enter_fwd | output | 1 | That operation was admitted using the forwarded result |
| exec_valid | output | 1 | Execution-complete pulse from writeback |
| exec_dst | output | RW | Destination of the completing operation |

## Verification
If a writer count is left high or cleared too early, a dependent's enter pulse appears early or late. Within about five cycles the completion spacing differs from 4 (forwarded) or from the issue gap (late arrival), and the forwarding tag flips. A queue that compacts wrongly after a middle removal shows up as a missing, duplicated or reordered completion pulse in the next few cycles. A late-stage fault shows up as a break in the fixed 4-cycle distance between the enter and completion pulses of one destination.

// File: rtl/valu_fwd_pkg.sv
package valu_fwd_pkg;

  // Writers of a register that still block a reader once the one in
  // writeback and the one being forwarded are taken away.
  function automatic int unsigned writers_left(input int unsigned pend,
                                               input logic wb_hit,
                                               input logic fwd_hit);
    int unsigned taken;
    taken = int'(wb_hit) + int'(fwd_hit);
    return (pend > taken) ? pend - taken : 0;
  endfunction

  // A used source stalls if any writer is still outstanding or an older
  // queued entry will write it.
  function automatic logic src_stalls(input logic used,
                                      input int unsigned left,
                                      input logic older_writer);
    return used && ((left != 0) || older_writer);
  endfunction

endpackage

// File: rtl/valu_scoreboard.sv
module valu_scoreboard #(
  parameter int NUM_REGS = 16,
  parameter int RW       = 4,
  parameter int CW       = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 set_vld,
  input  logic [RW-1:0]        set_dst,
  input  logic                 clr_vld,
  input  logic [RW-1:0]        clr_dst,
  output logic [NUM_REGS*CW-1:0] pend_flat
);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [CW-1:0] cnt;
    logic          inc;
    logic          dec;

    assign inc = set_vld && (set_dst == RW'(r));
    assign dec = clr_vld && (clr_dst == RW'(r));

    always_ff @(posedge clk) begin
      if (rst)              cnt <= '0;
      else if (inc && !dec) cnt <= cnt + 1'b1;
      else if (dec && !inc) cnt <= cnt - 1'b1;
    end

    assign pend_flat[r*CW +: CW] = cnt;
  end

endmodule

// File: rtl/valu_dep_queue.sv
module valu_dep_queue
  import valu_fwd_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int RW       = 4,
  parameter int CW       = 3,
  parameter int DEPTH    = 4,
  parameter int QCW      = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   push,
  input  logic [RW-1:0]          push_dst,
  input  logic [RW-1:0]          push_sa,
  input  logic                   push_sau,
  input  logic [RW-1:0]          push_sb,
  input  logic                   push_sbu,
  input  logic [NUM_REGS*CW-1:0] pend_flat,
  input  logic                   wb_vld,
  input  logic [RW-1:0]          wb_dst,
  input  logic                   fw_vld,
  input  logic [RW-1:0]          fw_dst,
  output logic [QCW-1:0]         count,
  output logic                   full,
  output logic                   adm_vld,
  output logic [RW-1:0]          adm_dst,
  output logic                   adm_fwd
);

  localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef struct packed {
    logic [RW-1:0] dst;
    logic [RW-1:0] sa;
    logic          sau;
    logic [RW-1:0] sb;
    logic          sbu;
  } ent_t;

  ent_t          q [DEPTH];
  ent_t          new_ent;
  logic [DEPTH-1:0] ok;
  logic [SW-1:0] sel;
  logic          found;

  assign new_ent = '{dst: push_dst, sa: push_sa, sau: push_sau,
                     sb: push_sb, sbu: push_sbu};
  assign full    = (count == QCW'(DEPTH));

  function automatic int unsigned left_for(input logic [RW-1:0] src);
    logic [CW-1:0] p;
    p = pend_flat[int'(src)*CW +: CW];
    return writers_left(32'(p), wb_vld && (wb_dst == src),
                        fw_vld && (fw_dst == src));
  endfunction

  // Per-entry resolution and oldest-first pick.
  always_comb begin
    logic older_a;
    logic older_b;
    ok    = '0;
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      older_a = 1'b0;
      older_b = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (q[j].dst == q[i].sa) older_a = 1'b1;
        if (q[j].dst == q[i].sb) older_b = 1'b1;
      end
      ok[i] = (i < int'(count))
              && !src_stalls(q[i].sau, left_for(q[i].sa), older_a)
              && !src_stalls(q[i].sbu, left_for(q[i].sb), older_b);
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (ok[i] && !found) begin
        found = 1'b1;
        sel   = SW'(i);
      end
    end
  end

  assign adm_vld = found;
  assign adm_dst = q[sel].dst;
  assign adm_fwd = found && fw_vld &&
                   ((q[sel].sau && (q[sel].sa == fw_dst)) ||
                    (q[sel].sbu && (q[sel].sb == fw_dst)));

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + QCW'(push) - QCW'(adm_vld);
  end

  // Compacting storage: entries above the removed one slide down,
  // a new entry lands just past the surviving ones.
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (adm_vld && (i >= int'(sel))) q[i] <= q[(i + 1) % DEPTH];
      if (push && (i == int'(count) - int'(adm_vld))) q[i] <= new_ent;
    end
  end

endmodule

// File: rtl/valu_stage_pipe.sv
module valu_stage_pipe #(
  parameter int RW     = 4,
  parameter int STAGES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [RW-1:0] in_dst,
  input  logic          in_fwd,
  output logic          enter_vld,
  output logic [RW-1:0] enter_dst,
  output logic          enter_fwd,
  output logic          last_vld,
  output logic [RW-1:0] last_dst,
  output logic          wb_vld,
  output logic [RW-1:0] wb_dst
);

  logic          vld [STAGES];
  logic [RW-1:0] dst [STAGES];
  logic          fwd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) vld[k] <= 1'b0;
      fwd0   <= 1'b0;
      wb_vld <= 1'b0;
    end else begin
      vld[0] <= in_vld;
      for (int k = 1; k < STAGES; k++) vld[k] <= vld[k-1];
      fwd0   <= in_vld && in_fwd;
      wb_vld <= vld[STAGES-1];
    end
  end

  always_ff @(posedge clk) begin
    dst[0] <= in_dst;
    for (int k = 1; k < STAGES; k++) dst[k] <= dst[k-1];
    wb_dst <= dst[STAGES-1];
  end

  assign enter_vld = vld[0];
  assign enter_dst = dst[0];
  assign enter_fwd = fwd0;
  assign last_vld  = vld[STAGES-1];
  assign last_dst  = dst[STAGES-1];

endmodule

// File: rtl/valu_fwd_pipe.sv
module valu_fwd_pipe #(
  parameter int NUM_REGS   = 16,
  parameter int Q_DEPTH    = 4,
  parameter int ALU_STAGES = 4,
  localparam int RW        = $clog2(NUM_REGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue_valid,
  output logic          issue_ready,
  input  logic [RW-1:0] issue_dst,
  input  logic [RW-1:0] issue_src_a,
  input  logic          issue_src_a_used,
  input  logic [RW-1:0] issue_src_b,
  input  logic          issue_src_b_used,
  output logic          enter_valid,
  output logic [RW-1:0] enter_dst,
  output logic          enter_fwd,
  output logic          exec_valid,
  output logic [RW-1:0] exec_dst
);

  localparam int CW  = $clog2(ALU_STAGES + 2);
  localparam int QCW = $clog2(Q_DEPTH + 1);

  logic [NUM_REGS*CW-1:0] pend_flat;
  logic [QCW-1:0]         q_count;
  logic                   q_full;
  logic                   adm_vld;
  logic [RW-1:0]          adm_dst;
  logic                   adm_fwd;
  logic                   fw_vld;
  logic [RW-1:0]          fw_dst;
  logic                   wb_vld;
  logic [RW-1:0]          wb_dst;
  logic                   wb_pend_nz;

  assign issue_ready = !q_full;

  valu_dep_queue #(
    .NUM_REGS(NUM_REGS), .RW(RW), .CW(CW), .DEPTH(Q_DEPTH), .QCW(QCW)
  ) u_queue (
    .clk(clk), .rst(rst),
    .push(issue_valid && issue_ready),
    .push_dst(issue_dst),
    .push_sa(issue_src_a), .push_sau(issue_src_a_used),
    .push_sb(issue_src_b), .push_sbu(issue_src_b_used),
    .pend_flat(pend_flat),
    .wb_vld(wb_vld), .wb_dst(wb_dst),
    .fw_vld(fw_vld), .fw_dst(fw_dst),
    .count(q_count), .full(q_full),
    .adm_vld(adm_vld), .adm_dst(adm_dst), .adm_fwd(adm_fwd)
  );

  valu_stage_pipe #(.RW(RW), .STAGES(ALU_STAGES)) u_pipe (
    .clk(clk), .rst(rst),
    .in_vld(adm_vld), .in_dst(adm_dst), .in_fwd(adm_fwd),
    .enter_vld(enter_valid), .enter_dst(enter_dst), .enter_fwd(enter_fwd),
    .last_vld(fw_vld), .last_dst(fw_dst),
    .wb_vld(wb_vld), .wb_dst(wb_dst)
  );

  valu_scoreboard #(.NUM_REGS(NUM_REGS), .RW(RW), .CW(CW)) u_sb (
    .clk(clk), .rst(rst),
    .set_vld(adm_vld), .set_dst(adm_dst),
    .clr_vld(wb_vld), .clr_dst(wb_dst),
    .pend_flat(pend_flat)
  );

  assign wb_pend_nz = (pend_flat[int'(wb_dst)*CW +: CW] != '0);
  assign exec_valid = wb_vld;
  assign exec_dst   = wb_dst;

endmodule

// File: rtl/valu_fwd_pipe_chk.sv
module valu_fwd_pipe_chk #(
  parameter int RW    = 4,
  parameter int QCW   = 3,
  parameter int DEPTH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           enter_valid,
  input logic [RW-1:0]  enter_dst,
  input logic           enter_fwd,
  input logic           exec_valid,
  input logic [RW-1:0]  exec_dst,
  input logic [QCW-1:0] q_count,
  input logic           wb_pend_nz
);

  logic [2:0] seen;

  always_ff @(posedge clk) begin
    if (rst)              seen <= '0;
    else if (seen != 3'd7) seen <= seen + 3'd1;
  end

  // R3: completion lands exactly four cycles after stage-0 entry
  a_r3_exec_after_enter: assert property (@(posedge clk) disable iff (rst)
    (seen >= 3'd4 && exec_valid) |->
      ($past(enter_valid, 4) && ($past(enter_dst, 4) == exec_dst)));

  // R4: a forwarded admission means the producer is completing now
  a_r4_fwd_with_exec: assert property (@(posedge clk) disable iff (rst)
    (enter_valid && enter_fwd) |-> exec_valid);

  // R10: queue occupancy never exceeds its depth
  a_r10_queue_bound: assert property (@(posedge clk) disable iff (rst)
    q_count <= QCW'(DEPTH));

  // R1: nothing leaves the pipeline right after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!enter_valid && !exec_valid));

  // R9: every completion retires a counted writer
  a_r9_exec_counted: assert property (@(posedge clk) disable iff (rst)
    exec_valid |-> wb_pend_nz);

endmodule

bind valu_fwd_pipe valu_fwd_pipe_chk #(.RW(RW), .QCW(QCW), .DEPTH(Q_DEPTH)) u_chk (
  .clk(clk), .rst(rst),
  .enter_valid(enter_valid), .enter_dst(enter_dst), .enter_fwd(enter_fwd),
  .exec_valid(exec_valid), .exec_dst(exec_dst),
  .q_count(q_count), .wb_pend_nz(wb_pend_nz)
);

// File: tb/valu_fwd_pipe_tb.sv
`timescale 1ns/1ps
module valu_fwd_pipe_tb_top;

  localparam int NREG = 16;

  logic       clk = 1'b0;
  logic       rst;
  logic       issue_valid;
  logic       issue_ready;
  logic [3:0] issue_dst, issue_src_a, issue_src_b;
  logic       issue_src_a_used, issue_src_b_used;
  logic       enter_valid, enter_fwd, exec_valid;
  logic [3:0] enter_dst, exec_dst;

  always #2.5 clk = ~clk;

  valu_fwd_pipe dut_i (
    .clk(clk), .rst(rst),
    .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_dst(issue_dst),
    .issue_src_a(issue_src_a), .issue_src_a_used(issue_src_a_used),
    .issue_src_b(issue_src_b), .issue_src_b_used(issue_src_b_used),
    .enter_valid(enter_valid), .enter_dst(enter_dst), .enter_fwd(enter_fwd),
    .exec_valid(exec_valid), .exec_dst(exec_dst)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit busy_seen;

  int exec_at [NREG];
  int enter_at[NREG];
  bit fwd_at  [NREG];
  int exec_order[32];
  int exec_n;

  always @(negedge clk) begin
    if (exec_valid) begin
      exec_at[exec_dst] = cyc;
      if (exec_n < 32) exec_order[exec_n] = int'(exec_dst);
      exec_n++;
    end
    if (enter_valid) begin
      enter_at[enter_dst] = cyc;
      fwd_at[enter_dst]   = enter_fwd;
    end
  end

  typedef struct packed {
    logic [3:0] gap;
    logic [3:0] sa;
    logic       sau;
    logic [3:0] sb;
    logic       sbu;
    logic [3:0] dly;
    logic       tag;
  } row_t;

  // producer writes r3 from constants; consumer writes r7 after 'gap' cycles
  localparam row_t ROWS [8] = '{
    '{4'd1, 4'd3, 1'b1, 4'd0, 1'b0, 4'd4, 1'b1},
    '{4'd2, 4'd5, 1'b1, 4'd3, 1'b1, 4'd4, 1'b1},
    '{4'd1, 4'd5, 1'b1, 4'd6, 1'b1, 4'd1, 1'b0},
    '{4'd4, 4'd3, 1'b1, 4'd3, 1'b1, 4'd4, 1'b1},
    '{4'd5, 4'd3, 1'b1, 4'd0, 1'b0, 4'd5, 1'b0},
    '{4'd7, 4'd3, 1'b1, 4'd0, 1'b0, 4'd7, 1'b0},
    '{4'd1, 4'd3, 1'b0, 4'd3, 1'b0, 4'd1, 1'b0},
    '{4'd3, 4'd0, 1'b0, 4'd3, 1'b1, 4'd4, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    for (int i = 0; i < NREG; i++) begin
      exec_at[i] = -1; enter_at[i] = -1; fwd_at[i] = 1'b0;
    end
    exec_n = 0;
    busy_seen = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    issue_valid = 1'b0;
    idle(2);
    rst = 1'b0;
    clear_log();
  endtask

  task automatic issue(input int dst, input int sa, input bit sau,
                       input int sb, input bit sbu, output int at);
    issue_valid      = 1'b1;
    issue_dst        = dst[3:0];
    issue_src_a      = sa[3:0];
    issue_src_a_used = sau;
    issue_src_b      = sb[3:0];
    issue_src_b_used = sbu;
    while (!issue_ready) begin
      busy_seen = 1'b1;
      @(negedge clk);
    end
    at = cyc;
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int t, t1, t2, tf;
    issue_valid = 1'b0;
    issue_dst = '0; issue_src_a = '0; issue_src_b = '0;
    issue_src_a_used = 1'b0; issue_src_b_used = 1'b0;
    clear_log();
    @(negedge clk);
    do_reset();

    // R1: reset state at the ports
    chk("R1 ready after reset", int'(issue_ready), 1);
    chk("R1 no enter after reset", int'(enter_valid), 0);
    chk("R1 no exec after reset", int'(exec_valid), 0);

    // R4 R5 R6: table of producer/consumer pairs
    for (int r = 0; r < 8; r++) begin
      do_reset();
      issue(3, 0, 1'b0, 0, 1'b0, t);
      idle(int'(ROWS[r].gap) - 1);
      issue(7, int'(ROWS[r].sa), ROWS[r].sau, int'(ROWS[r].sb), ROWS[r].sbu, t1);
      idle(20);
      chk($sformatf("R4/R5/R6 row %0d exec spacing", r),
          exec_at[7] - exec_at[3], int'(ROWS[r].dly));
      chk($sformatf("R4/R5/R6 row %0d fwd tag", r),
          int'(fwd_at[7]), int'(ROWS[r].tag));
    end

    // R2 R3: base latency
    do_reset();
    issue(9, 0, 1'b0, 0, 1'b0, t);
    idle(10);
    chk("R2 enter cycle", enter_at[9], t + 2);
    chk("R2 exec cycle", exec_at[9], t + 6);
    chk("R3 enter to exec", exec_at[9] - enter_at[9], 4);

    // R4 R8: chain where the third reads a still-queued producer
    do_reset();
    issue(1, 0, 1'b0, 0, 1'b0, t);
    issue(2, 1, 1'b1, 0, 1'b0, t1);
    issue(4, 2, 1'b1, 0, 1'b0, t2);
    idle(20);
    chk("R4 chain first", exec_at[1], t + 6);
    chk("R4 chain second", exec_at[2], t + 10);
    chk("R8 chain third waits", exec_at[4], t + 14);
    chk("R8 chain third fwd", int'(fwd_at[4]), 1);

    // R7: younger independent passes a blocked older entry
    do_reset();
    issue(1, 0, 1'b0, 0, 1'b0, t);
    issue(2, 1, 1'b1, 0, 1'b0, t1);
    issue(3, 0, 1'b0, 0, 1'b0, t2);
    idle(20);
    chk("R7 bypass exec", exec_at[3], t + 8);
    chk("R7 blocked exec", exec_at[2], t + 10);
    chk("R7 order second", exec_order[1], 3);
    chk("R7 order third", exec_order[2], 2);

    // R9: two writers of r1, reader waits for the younger
    do_reset();
    issue(1, 0, 1'b0, 0, 1'b0, t);
    issue(1, 0, 1'b0, 0, 1'b0, t1);
    issue(5, 1, 1'b1, 0, 1'b0, t2);
    idle(20);
    chk("R9 reader exec", exec_at[5], t + 11);
    chk("R9 reader fwd", int'(fwd_at[5]), 1);

    // R10: fill the queue behind one producer
    do_reset();
    issue(1, 0, 1'b0, 0, 1'b0, t);
    for (int k = 2; k <= 6; k++) issue(k, 1, 1'b1, 0, 1'b0, tf);
    idle(25);
    chk("R10 backpressure seen", int'(busy_seen), 1);
    chk("R10 last accept cycle", tf, t + 6);
    for (int k = 2; k <= 6; k++)
      chk($sformatf("R10 exec of r%0d", k), exec_at[k], t + 8 + k);
    chk("R10 all completed", exec_n, 6);
    chk("R10 first fwd", int'(fwd_at[2]), 1);
    chk("R10 second no fwd", int'(fwd_at[3]), 0);

    // R1: reset while an operation is in flight
    do_reset();
    issue(8, 0, 1'b0, 0, 1'b0, t);
    idle(2);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    idle(12);
    chk("R1 flushed op never completes", exec_at[8] > t + 3 ? 1 : 0, 0);
    chk("R1 ready after mid reset", int'(issue_ready), 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule